// File: doc/BRIEF.md
# Asynchronous Byte-Lane Static RAM Controller

This block sits between a synchronous single-master request port and an external asynchronous static RAM with a 17-bit word address, a 16-bit data bus and independent active-low strobes for the lower and upper byte lanes. A master presents a read or write with a two-bit byte mask using a valid/ready handshake. The controller then drives the chip select, write enable, output enable and the two lane enables through a fixed sequence. It finishes by issuing a one-cycle done pulse, which carries masked read data for reads.

All timing windows are counted in clock cycles. The counts are derived at elaboration from the memory's nanosecond minimums and the clock period, rounded up, so no programmable state is needed. The tri-state data bus is split into an output value, an input value and a driver enable. The controller drives the bus only while write enable is low plus one hold cycle, and keeps output enable high throughout every write, so the two sides never drive the bus at once.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n and ram_ub_n are all 1, ram_dq_oe and done are 0, and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. From the next cycle req_ready stays 0 until the cycle in which done is 1, when it returns to 1.
- R3: A read drives the address, ram_cs_n=0, ram_oe_n=0 and the selected lane enables low at the accept edge, with ram_we_n=1. These levels are held for RD_CYC = ceil(T_RC_NS/CLK_PERIOD_NS) cycles (7 with defaults). done appears 7 clock edges after the accept edge.
- R4: The byte mask has bit 0 for the lower lane (data bits 7:0, ram_lb_n) and bit 1 for the upper lane (bits 15:8, ram_ub_n). A read's rd_data holds the sampled bus byte for every enabled lane and 8'h00 for every disabled lane.
- R5: A write first spends one cycle with the address driven and all strobes high. Then ram_we_n, ram_cs_n and the selected lane enables fall on the same edge, and ram_oe_n stays 1 for the whole write.
- R6: ram_we_n stays low for WP_CYC cycles, where WP_CYC = max(ceil(T_WP/T), ceil(T_DW/T), ceil(T_WC/T)-2). This is 6 with defaults.
- R7: ram_dq_oe is 1 from the edge where ram_we_n falls until one cycle after it rises, and ram_dq_out carries the write data during that time. ram_dq_oe is never 1 while ram_oe_n is 0.
- R8: A write ends with done one cycle after ram_we_n rises, which is 8 edges after the accept edge. rd_data is 16'h0000 in that cycle.
- R9: A request with mask 2'b00 never asserts a lane enable. A write with this mask leaves memory unchanged, and a read with it returns 16'h0000. Both still complete with done.
- R10: While req_valid is 0 and the controller is idle, all strobes stay high and ram_dq_oe stays 0.
- R11: done is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Masked read data, valid with done |
| ram_addr | output | 17 | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_lb_n | output | 1 | RAM lower lane enable, active low |
| ram_ub_n | output | 1 | RAM upper lane enable, active low |
| ram_dq_out | output | 16 | Value driven onto the data bus |
| ram_dq_oe | output | 1 | Data bus driver enable |
| ram_dq_in | input | 16 | Value sampled from the data bus |

## Verification
Directed reads use lower-only, upper-only, both-lane and empty masks. The RAM model drives junk on disabled lanes, so these reads separate correct per-lane masking from capture of the whole bus. Partial-lane writes followed by full reads show whether the lane enables protect the untouched byte, and the top address checks the full address width. A few hundred random reads and writes over a small, frequently revisited address set are checked against a bench shadow memory. A strobe monitor throughout measures every write-enable and read window length and flags bus contention or undriven write data.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CW     = 4,
  parameter int RD_CYC = 7,
  parameter int WP_CYC = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_expired,
  output logic          req_ready,
  output logic          ld,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          lane_on_nx,
  output logic          cap_rd,
  output logic          clr_rd,
  output logic          cs_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe,
  output logic          done
);

  seq_state_t st_q, st_nx;
  logic cs_nx, we_nx, oe_nx, drv_nx, done_nx;

  always_comb begin
    st_nx      = st_q;
    ld         = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    cs_nx      = 1'b1;
    we_nx      = 1'b1;
    oe_nx      = 1'b1;
    drv_nx     = 1'b0;
    lane_on_nx = 1'b0;
    done_nx    = 1'b0;
    cap_rd     = 1'b0;
    clr_rd     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld = 1'b1;
          if (req_write) begin
            st_nx = ST_WSETUP;
          end else begin
            st_nx      = ST_READ;
            tmr_load   = 1'b1;
            tmr_val    = CW'(RD_CYC - 1);
            cs_nx      = 1'b0;
            oe_nx      = 1'b0;
            lane_on_nx = 1'b1;
          end
        end
      end
      ST_READ: begin
        if (tmr_expired) begin
          st_nx   = ST_IDLE;
          done_nx = 1'b1;
          cap_rd  = 1'b1;
        end else begin
          cs_nx      = 1'b0;
          oe_nx      = 1'b0;
          lane_on_nx = 1'b1;
        end
      end
      ST_WSETUP: begin
        st_nx      = ST_WPULSE;
        tmr_load   = 1'b1;
        tmr_val    = CW'(WP_CYC - 1);
        cs_nx      = 1'b0;
        we_nx      = 1'b0;
        lane_on_nx = 1'b1;
        drv_nx     = 1'b1;
      end
      ST_WPULSE: begin
        drv_nx = 1'b1;
        if (tmr_expired) begin
          st_nx = ST_WHOLD;
        end else begin
          cs_nx      = 1'b0;
          we_nx      = 1'b0;
          lane_on_nx = 1'b1;
        end
      end
      ST_WHOLD: begin
        st_nx   = ST_IDLE;
        done_nx = 1'b1;
        clr_rd  = 1'b1;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cs_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      st_q  <= st_nx;
      cs_n  <= cs_nx;
      we_n  <= we_nx;
      oe_n  <= oe_nx;
      dq_oe <= drv_nx;
      done  <= done_nx;
    end
  end

  assign req_ready = (st_q == ST_IDLE);

  // Window length counters used only by the checks below
  logic [CW:0] wlow_q, rlow_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      wlow_q <= '0;
      rlow_q <= '0;
    end else begin
      wlow_q <= we_n ? '0 : wlow_q + 1'b1;
      rlow_q <= oe_n ? '0 : rlow_q + 1'b1;
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);
  p_select_is_access_r5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && oe_n) |-> !we_n);
  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);
  p_drive_holds_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> dq_oe);
  p_drive_release_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |=> !dq_oe);
  p_wp_width_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (wlow_q >= (CW+1)'(WP_CYC)));
  p_rd_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_n) |-> (rlow_q >= (CW+1)'(RD_CYC)));

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int AW    = 17,
  parameter int DW    = 16,
  parameter int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  input  logic             lane_on_nx,
  input  logic             cap_rd,
  input  logic             clr_rd,
  input  logic [DW-1:0]    dq_in,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdata_q,
  output logic [LANES-1:0] lane_n,
  output logic [DW-1:0]    rd_data
);

  logic [LANES-1:0] be_q;
  logic [LANES-1:0] be_sel;

  assign be_sel = ld ? req_be : be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (ld) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_n[i] <= 1'b1;
      end else begin
        lane_n[i] <= ~(lane_on_nx & be_sel[i]);
      end
    end

    always_ff @(posedge clk) begin
      if (rst || clr_rd) begin
        rd_data[8*i +: 8] <= 8'h00;
      end else if (cap_rd) begin
        rd_data[8*i +: 8] <= be_q[i] ? dq_in[8*i +: 8] : 8'h00;
      end
    end

    p_lane_quiet_when_masked_r9: assert property (@(posedge clk) disable iff (rst)
      (!ld && !be_q[i]) |=> lane_n[i]);
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW            = 17,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_RC_NS       = 55,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 45,
  parameter int T_DW_NS       = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cs_n,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic          ram_lb_n,
  output logic          ram_ub_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  localparam int LANES  = DW / 8;
  localparam int RD_CYC = ceil_div(T_RC_NS, CLK_PERIOD_NS);
  localparam int WP_CYC = max3(ceil_div(T_WP_NS, CLK_PERIOD_NS),
                               ceil_div(T_DW_NS, CLK_PERIOD_NS),
                               ceil_div(T_WC_NS, CLK_PERIOD_NS) - 2);
  localparam int CMAX   = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int CW     = $clog2(CMAX + 1);

  logic          ld, tmr_load, tmr_expired, lane_on_nx, cap_rd, clr_rd;
  logic [CW-1:0] tmr_val;
  logic [LANES-1:0] lane_n;

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  asram_seq #(.CW(CW), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .tmr_expired (tmr_expired),
    .req_ready   (req_ready),
    .ld          (ld),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .lane_on_nx  (lane_on_nx),
    .cap_rd      (cap_rd),
    .clr_rd      (clr_rd),
    .cs_n        (ram_cs_n),
    .we_n        (ram_we_n),
    .oe_n        (ram_oe_n),
    .dq_oe       (ram_dq_oe),
    .done        (done)
  );

  asram_dpath #(.AW(AW), .DW(DW), .LANES(LANES)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .ld         (ld),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be[LANES-1:0]),
    .lane_on_nx (lane_on_nx),
    .cap_rd     (cap_rd),
    .clr_rd     (clr_rd),
    .dq_in      (ram_dq_in),
    .addr_q     (ram_addr),
    .wdata_q    (ram_dq_out),
    .lane_n     (lane_n),
    .rd_data    (rd_data)
  );

  assign ram_lb_n = lane_n[0];
  assign ram_ub_n = lane_n[LANES-1];

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe));
  p_lane_needs_select_r3: assert property (@(posedge clk) disable iff (rst)
    (!ram_lb_n || !ram_ub_n) |-> !ram_cs_n);
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
    !ram_cs_n |-> !req_ready);

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr  = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be    = '0;
  logic        req_ready, done;
  logic [15:0] rd_data;
  logic [16:0] ram_addr;
  logic        ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, ram_dq_oe;
  logic [15:0] ram_dq_out;
  logic [15:0] ram_dq_in = 16'hDEAD;

  always #4 clk = ~clk;

  asram_ctrl u_dut (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .done       (done),
    .rd_data    (rd_data),
    .ram_addr   (ram_addr),
    .ram_cs_n   (ram_cs_n),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .ram_lb_n   (ram_lb_n),
    .ram_ub_n   (ram_ub_n),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe),
    .ram_dq_in  (ram_dq_in)
  );

  function automatic logic [15:0] init_word(input logic [16:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] ^ {7'h1E, a[16]}};
  endfunction

  // Behavioural RAM and strobe monitor
  logic [15:0] mem [int];
  int mon_checks = 0;
  int mon_fails  = 0;
  int we_run = 0;
  int rd_run = 0;

  function automatic logic [15:0] mem_rd(input logic [16:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return init_word(a);
  endfunction

  always @(negedge clk) begin
    logic [15:0] w;
    if (!rst) begin
      if (!ram_cs_n && !ram_we_n) begin
        w = mem_rd(ram_addr);
        if (!ram_lb_n) w[7:0]  = ram_dq_out[7:0];
        if (!ram_ub_n) w[15:8] = ram_dq_out[15:8];
        mem[int'(ram_addr)] = w;
        mon_checks++;
        if (!ram_dq_oe) begin
          mon_fails++;
          $display("FAIL R7 write data undriven: act dq_oe=%0b exp 1", ram_dq_oe);
        end
        if (!ram_oe_n) begin
          mon_fails++;
          $display("FAIL R5 oe low during write: act %0b exp 1", ram_oe_n);
        end
      end
      if (ram_dq_oe && !ram_cs_n && ram_we_n && !ram_oe_n) begin
        mon_fails++;
        $display("FAIL R7 bus contention: act dq_oe=1 oe_n=0 exp no overlap");
      end
      if (!ram_cs_n && ram_we_n && !ram_oe_n) begin
        w = mem_rd(ram_addr);
        ram_dq_in <= {ram_ub_n ? 8'h5A : w[15:8], ram_lb_n ? 8'hA5 : w[7:0]};
      end else begin
        ram_dq_in <= 16'hDEAD;
      end
      if (!ram_we_n) we_run++;
      else if (we_run > 0) begin
        mon_checks++;
        if (we_run < 6) begin
          mon_fails++;
          $display("FAIL R6 write pulse: act %0d exp >= 6", we_run);
        end
        we_run = 0;
      end
      if (!ram_oe_n) rd_run++;
      else if (rd_run > 0) begin
        mon_checks++;
        if (rd_run < 7) begin
          mon_fails++;
          $display("FAIL R3 read window: act %0d exp >= 7", rd_run);
        end
        rd_run = 0;
      end
    end
  end

  // Checking infrastructure
  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] shadow [int];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] shadow_rd(input logic [16:0] a);
    if (shadow.exists(int'(a))) return shadow[int'(a)];
    return init_word(a);
  endfunction

  function automatic logic [15:0] masked(input logic [15:0] v, input logic [1:0] m);
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic do_op(input bit wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    int lat;
    logic [15:0] e;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_be    = m;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~d;
    chk(req_ready == 1'b0, "R2 ready low while busy", {31'd0, req_ready}, 32'd0);
    chk(ram_addr == a, "R3 address driven", {15'd0, ram_addr}, {15'd0, a});
    if (wr) begin
      chk({ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n} == 5'b11111,
          "R5 setup cycle strobes high",
          {27'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n}, 32'h1F);
    end else begin
      chk({ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n} == {3'b010, ~m[0], ~m[1]},
          "R3 read strobes at accept",
          {27'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n},
          {27'd0, 3'b010, ~m[0], ~m[1]});
    end
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (wr && lat == 1) begin
        chk({ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n} == {3'b001, ~m[0], ~m[1]},
            "R5 pulse start strobes",
            {27'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n},
            {27'd0, 3'b001, ~m[0], ~m[1]});
        chk(ram_dq_oe && ram_dq_out == d, "R7 bus driven with data",
            {15'd0, ram_dq_oe, ram_dq_out}, {15'd0, 1'b1, d});
      end
    end while (!done && lat < 20);
    if (wr) begin
      e = shadow_rd(a);
      if (m[0]) e[7:0]  = d[7:0];
      if (m[1]) e[15:8] = d[15:8];
      shadow[int'(a)] = e;
      chk(lat == 8, "R8 write latency", lat, 32'd8);
      chk(rd_data == 16'h0000, "R8 write done data", {16'd0, rd_data}, 32'd0);
      chk(ram_dq_oe == 1'b0, "R7 bus released at done", {31'd0, ram_dq_oe}, 32'd0);
    end else begin
      e = masked(shadow_rd(a), m);
      chk(lat == 7, "R3 read latency", lat, 32'd7);
      chk(rd_data == e, (m == 2'b00) ? "R9 empty mask read" : "R4 masked read data",
          {16'd0, rd_data}, {16'd0, e});
    end
    chk(req_ready == 1'b1, "R2 ready with done", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    chk(done == 1'b0, "R11 single-cycle done", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: act timeout exp completion");
    $display("  == %0d vectors applied, %0d miscompares ==",
             n_checks + mon_checks, n_fails + mon_fails);
    $finish;
  end

  initial begin
    logic [16:0] a;
    logic [1:0]  m;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n} == 5'b11111, "R1 reset strobes",
        {27'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n}, 32'h1F);
    chk(!ram_dq_oe && !done && req_ready, "R1 reset outputs",
        {29'd0, ram_dq_oe, done, req_ready}, 32'd1);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk({ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, ram_dq_oe} == 6'b111110,
          "R10 idle strobes",
          {26'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_lb_n, ram_ub_n, ram_dq_oe}, 32'h3E);
    end
    do_op(1'b1, 17'h12345, 16'hBEEF, 2'b11);
    do_op(1'b0, 17'h12345, 16'h0000, 2'b11);
    do_op(1'b0, 17'h12345, 16'h0000, 2'b01);
    do_op(1'b0, 17'h12345, 16'h0000, 2'b10);
    do_op(1'b1, 17'h12345, 16'h7711, 2'b10);
    do_op(1'b0, 17'h12345, 16'h0000, 2'b11);
    do_op(1'b1, 17'h12345, 16'h0102, 2'b00);
    do_op(1'b0, 17'h12345, 16'h0000, 2'b11);
    do_op(1'b0, 17'h12345, 16'h0000, 2'b00);
    do_op(1'b1, 17'h1FFFF, 16'hA55A, 2'b11);
    do_op(1'b0, 17'h1FFFF, 16'h0000, 2'b11);
    do_op(1'b0, 17'h00000, 16'h0000, 2'b11);
    for (int i = 0; i < 400; i++) begin
      a = {($urandom % 2) ? 1'b1 : 1'b0, 12'h0A5, 4'($urandom % 16)};
      m = 2'($urandom % 4);
      do_op(1'($urandom % 2), a, 16'($urandom), m);
    end
    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==",
             n_checks + mon_checks, n_fails + mon_fails);
    $finish;
  end

endmodule